// File: doc/BRIEF.md
# Self-Checking Arithmetic and Logic Unit

This block is a 40-bit-wide datapath unit with two separately protected halves. The arithmetic side handles plain add, clamped add, plain subtract, clamped subtract, signed minimum, signed maximum and absolute value. A width control chooses the form of the operation: one 40-bit operation for accumulation, one 32-bit operation, two independent 16-bit lanes, or a fold form in which each operand's two 16-bit halves are combined with each other. The logic side computes AND, OR, XOR or NOT. It is built as two identical copies whose outputs are compared bit by bit.

Plain add and subtract in the 32-bit, dual-lane and fold forms are guarded by a modulo-3 residue code. The residues of the operands are derived inside the block. A predicted residue is formed from them, with the lane's carry or borrow folded in, and compared with the residue of the produced sum. In the 16-bit forms each lane is checked on its own. The clamped operations, min, max, absolute value and every 40-bit operation are not checked. The result and the error flag are registered together, so an error is reported on the same clock edge as the result it concerns. A two-bit fault-injection input lets a test corrupt the replica logic copy or bit 0 of the lane-0 adder output.

Top module: `sc_alu`

## Requirements
- R1: Opcode 3'b000 is a wrapping add and 3'b010 is a wrapping subtract (first minus second) at the selected width. In the 32-bit form, result bits 39:32 are zero and operand bits 39:32 are ignored.
- R2: Opcode 3'b001 (clamped add) and 3'b011 (clamped subtract) limit a signed overflow to the most positive or most negative value of the lane width.
- R3: Opcode 3'b100 returns the signed minimum and 3'b101 the signed maximum of the two lane inputs. Opcode 3'b110 returns the absolute value of the first lane input, and the most negative value maps to the most positive value.
- R4: Width mode 2'b00 is one 40-bit operation. Mode 2'b01 is one 32-bit operation on bits 31:0. Mode 2'b10 puts a[15:0] op b[15:0] into result[15:0] and a[31:16] op b[31:16] into result[31:16]. Mode 2'b11 puts a[15:0] op a[31:16] into result[15:0] and b[15:0] op b[31:16] into result[31:16]. Modes 01, 10 and 11 leave result[39:32] zero.
- R5: Opcode 3'b111 applies the logic select (2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOT) to all 40 bits regardless of width mode. NOT uses only the first operand.
- R6: Result and error flag are registered: inputs present before a rising clock edge show up at the outputs just after that edge, and not before.
- R7: While reset (active low, asynchronous) is asserted, the result is zero and the error flag is low.
- R8: With opcode 3'b111, fault_inj[0] corrupts bit 0 of the replica logic copy. The error flag then rises with the result, and the result still carries the primary copy's value. With any other opcode, fault_inj[0] has no effect on the error flag.
- R9: fault_inj[1] flips bit 0 of the lane-0 plain add/subtract output. This is bit 0 of the 40-bit, 32-bit or low 16-bit lane, whichever is active. For opcode 000 or 010 in modes 01, 10 and 11, this raises the error flag together with the corrupted result.
- R10: The error flag stays low for every fault-free operation. It also stays low for clamped, min, max and absolute operations and for all 40-bit operations, even when fault_inj[1] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 3 | Operation select |
| width_mode | input | 2 | Form select: 40-bit, 32-bit, dual lane, fold |
| logic_sel | input | 2 | Logic function when opcode is 3'b111 |
| fault_inj | input | 2 | Bit 0 corrupts replica logic copy, bit 1 corrupts lane-0 adder output |
| op_a | input | 40 | First operand |
| op_b | input | 40 | Second operand |
| result | output | 40 | Registered result |
| err | output | 1 | Registered error flag, aligned with result |

## Verification
The bench looks for mistakes in how the residue prediction accounts for carry-out and borrow. A 32-bit add that wraps, or a subtract whose result goes negative, would raise a false error if the wrapped-out bit were ignored. Clamping at both signed limits and absolute value of the most negative number are probed, where a design that wraps would return the opposite sign. Lane routing in the dual-lane and fold forms is tested with distinct halves, so swapped or mixed lanes give a visibly wrong word. The fault-injection cases confirm that an error is raised exactly where coverage is promised and nowhere else: a design that gated the flag wrongly would either miss the corrupted lane or flag unchecked operations.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_ADDS  = 3'b001,
        OP_SUB   = 3'b010,
        OP_SUBS  = 3'b011,
        OP_MIN   = 3'b100,
        OP_MAX   = 3'b101,
        OP_ABS   = 3'b110,
        OP_LOGIC = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        WM_WIDE = 2'b00,
        WM_WORD = 2'b01,
        WM_PAIR = 2'b10,
        WM_FOLD = 2'b11
    } width_mode_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } logic_fn_e;

endpackage

// File: rtl/sc_res3.sv
// Modulo-3 residue of a W-bit unsigned value: 4^k is congruent to 1 mod 3,
// so the residue is the sum of the 2-bit digits taken mod 3.
module sc_res3 #(
    parameter int W = 16
) (
    input  logic [W-1:0] v,
    output logic [1:0]   r
);
    localparam int ND = (W + 1) / 2;

    logic [2*ND-1:0] vx;
    assign vx = (2*ND)'(v);

    always_comb begin
        int unsigned acc;
        acc = 0;
        for (int i = 0; i < ND; i++) begin
            acc = acc + 32'(vx[2*i +: 2]);
        end
        r = 2'(acc % 3);
    end
endmodule

// File: rtl/sc_res_check.sv
// Residue checker for one add/subtract lane of even width W (2^W = 1 mod 3).
// add : res = p + q - cy*2^W  -> res3 = p3 + q3 - cy
// sub : res = p - q + bw*2^W  -> res3 = p3 - q3 + bw
module sc_res_check #(
    parameter int W = 16
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic [W-1:0] sum,
    input  logic         wrap,
    input  logic         is_sub,
    output logic         bad
);
    logic [1:0] rp, rq, rs;
    logic [3:0] tot;
    logic [1:0] pred;

    sc_res3 #(.W(W)) u_rp (.v(p),   .r(rp));
    sc_res3 #(.W(W)) u_rq (.v(q),   .r(rq));
    sc_res3 #(.W(W)) u_rs (.v(sum), .r(rs));

    always_comb begin
        tot = 4'(rp)
            + (is_sub ? 4'(2'd3 - rq) : 4'(rq))
            + (is_sub ? 4'(wrap) : 4'({wrap, 1'b0}));
        pred = 2'(tot % 4'd3);
        bad  = (pred != rs);
    end
endmodule

// File: rtl/sc_arith_lane.sv
// One signed arithmetic lane of width W; CHECK selects the residue-checked variant.
module sc_arith_lane
    import sc_alu_pkg::*;
#(
    parameter int W     = 16,
    parameter bit CHECK = 1'b1
) (
    input  alu_op_e      op,
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic         inj,
    output logic [W-1:0] res,
    output logic         bad
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] s_clean, d_clean, raw, neg_p;
    logic         is_sub, ovf_add, ovf_sub, lt;

    assign s_clean = p + q;
    assign d_clean = p - q;
    assign neg_p   = '0 - p;
    assign is_sub  = (op == OP_SUB) || (op == OP_SUBS);
    assign raw     = (is_sub ? d_clean : s_clean) ^ {{(W-1){1'b0}}, inj};
    assign ovf_add = (p[W-1] == q[W-1]) && (s_clean[W-1] != p[W-1]);
    assign ovf_sub = (p[W-1] != q[W-1]) && (d_clean[W-1] != p[W-1]);
    assign lt      = $signed(p) < $signed(q);

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: res = raw;
            OP_ADDS:        res = ovf_add ? (p[W-1] ? SMIN : SMAX) : s_clean;
            OP_SUBS:        res = ovf_sub ? (p[W-1] ? SMIN : SMAX) : d_clean;
            OP_MIN:         res = lt ? p : q;
            OP_MAX:         res = lt ? q : p;
            OP_ABS:         res = p[W-1] ? ((p == SMIN) ? SMAX : neg_p) : p;
            default:        res = '0;
        endcase
    end

    generate
        if (CHECK) begin : g_chk
            logic wrap;
            assign wrap = is_sub ? (p < q) : (s_clean < p);
            sc_res_check #(.W(W)) u_chk (
                .p      (p),
                .q      (q),
                .sum    (raw),
                .wrap   (wrap),
                .is_sub (is_sub),
                .bad    (bad)
            );
        end else begin : g_nochk
            assign bad = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sc_logic_copy.sv
// One copy of the bitwise logic unit; flip corrupts bit 0 for fault injection.
module sc_logic_copy
    import sc_alu_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    input  logic         flip,
    output logic [W-1:0] y
);
    logic [W-1:0] f;

    always_comb begin
        case (fn)
            LG_AND:  f = a & b;
            LG_OR:   f = a | b;
            LG_XOR:  f = a ^ b;
            default: f = ~a;
        endcase
        y = f ^ {{(W-1){1'b0}}, flip};
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_alu_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        opcode,
    input  logic [1:0]        width_mode,
    input  logic [1:0]        logic_sel,
    input  logic [1:0]        fault_inj,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic              err
);
    localparam int NLANE   = WORD_W / HALF_W;
    localparam int PAD_W   = DATA_W - WORD_W;
    localparam int NCOPY   = 2;

    alu_op_e     op_e;
    width_mode_e wm_e;
    logic_fn_e   fn_e;

    assign op_e = alu_op_e'(opcode);
    assign wm_e = width_mode_e'(width_mode);
    assign fn_e = logic_fn_e'(logic_sel);

    // ---------------- arithmetic side ----------------
    logic [DATA_W-1:0] wide_res;
    logic              wide_bad;
    logic [WORD_W-1:0] word_res;
    logic              word_bad;
    logic [HALF_W-1:0] a_h [NLANE];
    logic [HALF_W-1:0] b_h [NLANE];
    logic [HALF_W-1:0] h_res [NLANE];
    logic [NLANE-1:0]  h_bad;

    sc_arith_lane #(.W(DATA_W), .CHECK(1'b0)) u_wide (
        .op (op_e), .p (op_a), .q (op_b), .inj (fault_inj[1]),
        .res (wide_res), .bad (wide_bad)
    );

    sc_arith_lane #(.W(WORD_W), .CHECK(1'b1)) u_word (
        .op (op_e), .p (op_a[WORD_W-1:0]), .q (op_b[WORD_W-1:0]),
        .inj (fault_inj[1]), .res (word_res), .bad (word_bad)
    );

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_half
            logic [HALF_W-1:0] hp, hq;
            assign a_h[g] = op_a[g*HALF_W +: HALF_W];
            assign b_h[g] = op_b[g*HALF_W +: HALF_W];
            if (g == 0) begin : g_l0
                assign hp = a_h[0];
                assign hq = (wm_e == WM_FOLD) ? a_h[1] : b_h[0];
            end else begin : g_ln
                assign hp = (wm_e == WM_FOLD) ? b_h[0] : a_h[g];
                assign hq = b_h[g];
            end
            sc_arith_lane #(.W(HALF_W), .CHECK(1'b1)) u_lane (
                .op  (op_e), .p (hp), .q (hq),
                .inj ((g == 0) ? fault_inj[1] : 1'b0),
                .res (h_res[g]), .bad (h_bad[g])
            );
        end
    endgenerate

    logic [WORD_W-1:0] half_pack;
    always_comb begin
        for (int i = 0; i < NLANE; i++) begin
            half_pack[i*HALF_W +: HALF_W] = h_res[i];
        end
    end

    logic [DATA_W-1:0] arith_res;
    logic              arith_bad;
    always_comb begin
        case (wm_e)
            WM_WIDE: begin
                arith_res = wide_res;
                arith_bad = wide_bad;
            end
            WM_WORD: begin
                arith_res = {{PAD_W{1'b0}}, word_res};
                arith_bad = word_bad;
            end
            default: begin
                arith_res = {{PAD_W{1'b0}}, half_pack};
                arith_bad = |h_bad;
            end
        endcase
    end

    // ---------------- logic side: duplicated ----------------
    logic [DATA_W-1:0] lg_y [NCOPY];
    generate
        for (genvar c = 0; c < NCOPY; c++) begin : g_copy
            sc_logic_copy #(.W(DATA_W)) u_copy (
                .a (op_a), .b (op_b), .fn (fn_e),
                .flip ((c == NCOPY-1) ? fault_inj[0] : 1'b0),
                .y (lg_y[c])
            );
        end
    endgenerate

    // ---------------- combine and register ----------------
    logic              is_logic, is_checked;
    logic [DATA_W-1:0] next_res;
    logic              next_err;

    assign is_logic   = (op_e == OP_LOGIC);
    assign is_checked = ((op_e == OP_ADD) || (op_e == OP_SUB)) && (wm_e != WM_WIDE);
    assign next_res   = is_logic ? lg_y[0] : arith_res;
    assign next_err   = (is_logic && (lg_y[0] != lg_y[NCOPY-1]))
                      || (is_checked && arith_bad);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            err    <= 1'b0;
        end else begin
            result <= next_res;
            err    <= next_err;
        end
    end
endmodule

// File: rtl/sc_alu_chk.sv
module sc_alu_chk #(
    parameter int DATA_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        opcode,
    input logic [1:0]        width_mode,
    input logic [1:0]        logic_sel,
    input logic [1:0]        fault_inj,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] result,
    input logic              err
);
    logic is_checked, is_logic;
    assign is_logic   = (opcode == 3'b111);
    assign is_checked = ((opcode == 3'b000) || (opcode == 3'b010)) && (width_mode != 2'b00);

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && !err);

    assert_logic_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && fault_inj[0]) |=> err);

    assert_logic_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && !fault_inj[0]) |=> !err);

    assert_adder_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_checked && fault_inj[1]) |=> err);

    assert_adder_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_checked && !fault_inj[1]) |=> !err);

    assert_unchecked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_logic && !is_checked) |=> !err);

    assert_not_first_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && (logic_sel == 2'b11) && !fault_inj[0]) |=> (result == ~$past(op_a)));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_logic && (width_mode != 2'b00)) |=> (result[DATA_W-1:32] == '0));
endmodule

bind sc_alu sc_alu_chk #(.DATA_W(DATA_W)) u_sc_alu_chk (.*);

// File: tb/sc_alu_bench.sv
module sc_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  opcode = '0;
    logic [1:0]  width_mode = '0;
    logic [1:0]  logic_sel = '0;
    logic [1:0]  fault_inj = '0;
    logic [39:0] op_a = '0;
    logic [39:0] op_b = '0;
    logic [39:0] result;
    logic        err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sc_alu u_sc_alu (
        .clk (clk), .rst_n (rst_n), .opcode (opcode), .width_mode (width_mode),
        .logic_sel (logic_sel), .fault_inj (fault_inj), .op_a (op_a), .op_b (op_b),
        .result (result), .err (err)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  md;
        logic [1:0]  ls;
        logic [39:0] a;
        logic [39:0] b;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 2'd1, 2'd0, 40'hAB_7FFF_FFFF, 40'h00_0000_0001}, // R1 wrap, upper ignored
        '{3'd0, 2'd1, 2'd0, 40'h00_FFFF_FFFF, 40'h00_0000_0002}, // R1 carry out
        '{3'd2, 2'd1, 2'd0, 40'h00_0000_0005, 40'h00_0000_0007}, // R1 borrow
        '{3'd1, 2'd1, 2'd0, 40'h00_7FFF_FFF0, 40'h00_0000_0100}, // R2 clamp high
        '{3'd3, 2'd1, 2'd0, 40'h00_8000_0000, 40'h00_0000_0001}, // R2 clamp low
        '{3'd0, 2'd0, 2'd0, 40'h7F_FFFF_FFFF, 40'h00_0000_0001}, // R4 wide
        '{3'd1, 2'd2, 2'd0, 40'h00_7FFF_8000, 40'h00_0001_FFFF}, // R2 R4 lanes
        '{3'd2, 2'd2, 2'd0, 40'h00_0003_0010, 40'h00_0005_0001}, // R4 pair sub
        '{3'd0, 2'd3, 2'd0, 40'h00_1234_0001, 40'h00_FFFF_0002}, // R4 fold add
        '{3'd2, 2'd3, 2'd0, 40'h00_0001_0000, 40'h00_0000_0000}, // R4 fold sub
        '{3'd4, 2'd1, 2'd0, 40'h00_FFFF_FFFF, 40'h00_0000_0001}, // R3 min
        '{3'd5, 2'd2, 2'd0, 40'h00_8000_0005, 40'h00_7FFF_0003}, // R3 max lanes
        '{3'd6, 2'd1, 2'd0, 40'h00_8000_0000, 40'h00_0000_0000}, // R3 abs of most negative
        '{3'd6, 2'd0, 2'd0, 40'hFF_FFFF_FFFB, 40'h00_0000_0000}, // R3 abs wide
        '{3'd3, 2'd0, 2'd0, 40'h80_0000_0000, 40'h00_0000_0001}, // R2 wide clamp
        '{3'd7, 2'd1, 2'd0, 40'hF0_F0F0_F0F0, 40'hCC_CCCC_CCCC}, // R5 and
        '{3'd7, 2'd2, 2'd1, 40'hF0_F0F0_F0F0, 40'h0C_CCCC_CCCC}, // R5 or
        '{3'd7, 2'd3, 2'd2, 40'hF0_F0F0_F0F0, 40'hCC_CCCC_CCCC}, // R5 xor
        '{3'd7, 2'd0, 2'd3, 40'h12_3456_789A, 40'hFF_FFFF_FFFF}  // R5 not
    };

    function automatic logic [39:0] lane_m(logic [2:0] op, int w, logic [39:0] p, logic [39:0] q);
        logic [63:0] msk;
        longint sp, sq, r, mx, mn;
        msk = (64'd1 << w) - 64'd1;
        sp = longint'(64'(p) & msk);
        sq = longint'(64'(q) & msk);
        if (p[w-1]) sp = sp - (longint'(1) << w);
        if (q[w-1]) sq = sq - (longint'(1) << w);
        mx = (longint'(1) << (w-1)) - 1;
        mn = -mx - 1;
        case (op)
            3'd0: r = sp + sq;
            3'd1: begin r = sp + sq; if (r > mx) r = mx; if (r < mn) r = mn; end
            3'd2: r = sp - sq;
            3'd3: begin r = sp - sq; if (r > mx) r = mx; if (r < mn) r = mn; end
            3'd4: r = (sp < sq) ? sp : sq;
            3'd5: r = (sp > sq) ? sp : sq;
            3'd6: begin r = (sp < 0) ? -sp : sp; if (r > mx) r = mx; end
            default: r = 0;
        endcase
        return 40'(64'(r) & msk);
    endfunction

    function automatic logic [39:0] model(logic [2:0] op, logic [1:0] md, logic [1:0] ls,
                                          logic [39:0] a, logic [39:0] b);
        logic [15:0] lo, hi;
        if (op == 3'd7) begin
            case (ls)
                2'd0: return a & b;
                2'd1: return a | b;
                2'd2: return a ^ b;
                default: return ~a;
            endcase
        end
        case (md)
            2'd0: return lane_m(op, 40, a, b);
            2'd1: return lane_m(op, 32, {8'd0, a[31:0]}, {8'd0, b[31:0]});
            2'd2: begin
                lo = 16'(lane_m(op, 16, {24'd0, a[15:0]},  {24'd0, b[15:0]}));
                hi = 16'(lane_m(op, 16, {24'd0, a[31:16]}, {24'd0, b[31:16]}));
            end
            default: begin
                lo = 16'(lane_m(op, 16, {24'd0, a[15:0]}, {24'd0, a[31:16]}));
                hi = 16'(lane_m(op, 16, {24'd0, b[15:0]}, {24'd0, b[31:16]}));
            end
        endcase
        return {8'd0, hi, lo};
    endfunction

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] op, logic [1:0] md, logic [1:0] ls,
                         logic [39:0] a, logic [39:0] b, logic [1:0] fi);
        @(negedge clk);
        opcode = op; width_mode = md; logic_sel = ls;
        op_a = a; op_b = b; fault_inj = fi;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [39:0] e;
        // R7: reset state
        repeat (2) @(negedge clk);
        chk("R7 result in reset", result, '0);
        chk("R7 err in reset", {39'd0, err}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1..R5 with R10 (no fault, no error)
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].op, TBL[i].md, TBL[i].ls, TBL[i].a, TBL[i].b, 2'b00);
            chk($sformatf("R1-5 vec%0d result", i), result,
                model(TBL[i].op, TBL[i].md, TBL[i].ls, TBL[i].a, TBL[i].b));
            chk($sformatf("R10 vec%0d err", i), {39'd0, err}, '0);
        end

        // R6: output changes only at the edge after inputs are applied
        apply(3'd0, 2'd1, 2'd0, 40'd10, 40'd20, 2'b00);
        @(negedge clk);
        opcode = 3'd0; width_mode = 2'd1; op_a = 40'd100; op_b = 40'd1;
        #5;
        chk("R6 before edge", result, 40'd30);
        @(negedge clk);
        chk("R6 after edge", result, 40'd101);

        // R8: replica logic copy corrupted
        apply(3'd7, 2'd0, 2'd2, 40'h55_0000_00F0, 40'h0F_0000_000F, 2'b01);
        chk("R8 logic fault err", {39'd0, err}, 40'd1);
        chk("R8 primary result kept", result, 40'h5A_0000_00FF);
        apply(3'd0, 2'd1, 2'd0, 40'd3, 40'd4, 2'b01);
        chk("R8 fault ignored for add", {39'd0, err}, '0);
        chk("R8 add result", result, 40'd7);

        // R9: adder output corrupted in checked forms
        apply(3'd0, 2'd1, 2'd0, 40'h00_FFFF_FFFF, 40'd2, 2'b10);
        chk("R9 word add err", {39'd0, err}, 40'd1);
        chk("R9 word add result", result, 40'd0);
        apply(3'd2, 2'd2, 2'd0, 40'h00_0003_0010, 40'h00_0005_0001, 2'b10);
        chk("R9 pair sub err", {39'd0, err}, 40'd1);
        chk("R9 pair sub result", result, 40'h00_FFFE_000E);
        apply(3'd0, 2'd3, 2'd0, 40'h00_1234_0001, 40'h00_FFFF_0002, 2'b10);
        chk("R9 fold add err", {39'd0, err}, 40'd1);

        // R10: unchecked operations stay quiet under adder fault
        apply(3'd0, 2'd0, 2'd0, 40'h7F_FFFF_FFFF, 40'd1, 2'b10);
        chk("R10 wide add err", {39'd0, err}, '0);
        chk("R10 wide add result", result, 40'h80_0000_0001);
        apply(3'd4, 2'd1, 2'd0, 40'd9, 40'd4, 2'b10);
        chk("R10 min err", {39'd0, err}, '0);
        chk("R10 min result", result, 40'd4);
        apply(3'd1, 2'd1, 2'd0, 40'd6, 40'd6, 2'b10);
        chk("R10 clamped add err", {39'd0, err}, '0);
        chk("R10 clamped add result", result, 40'd12);

        // R7: reset mid-run clears outputs
        apply(3'd7, 2'd0, 2'd0, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 2'b01);
        e = result;
        chk("R8 before reset", e, 40'hFF_FFFF_FFFF);
        rst_n = 1'b0;
        #2;
        chk("R7 async clear result", result, '0);
        chk("R7 async clear err", {39'd0, err}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule